// File: doc/BRIEF.md
# Repeater Backplane Bus Pad Interface

This block sits between one repeater port controller and the shared backplane bus that links several such controllers. It carries three classes of line. Two pass-through pins form a point-to-point acknowledge chain used by the arbitration scheme. A set of wired-OR status lines (activity and collision-present), which several devices may assert together, each get a separate drive pin and sense pin, so the device can observe the bus while it is driving it. A set of one-owner lines (enable, data, clock, collision), which only one device drives at a time, each share a single bidirectional pad.

The drive outputs of the wired-OR lines behave as open-drain: the pad enable follows the internal request, and the driven value is always the asserted level. A packet-enable signal turns on the shared-line pad drivers, and it is also brought out to steer an external transceiver. While it is high, sensing of the shared lines is blocked. A polarity input changes the wired-OR lines, and the shared lines chosen by a mask, from active low to active high, so the bus still works through inverting transceivers. Internal logic always sees active-high values. Sensed values are registered once.

Top module: `bb_bus_if`

## Requirements
- R1: While rst_ni is low, wor_sense_o and shr_rx_o are all zero.
- R2: For each wired-OR line, wor_drv_oe_o equals wor_act_i, and wor_drv_o equals the asserted level: 0 when invert_i=0 and 1 when invert_i=1.
- R3: One clock edge after sampling, wor_sense_o[k] is 1 exactly when wor_sense_i[k] was equal to the asserted level (0 when invert_i=0, 1 when invert_i=1).
- R4: Every bit of shr_oe_o equals pkt_en_i. shr_pad_o equals shr_tx_i XOR (LOW_MASK AND NOT invert_i), with bit 0 = enable, bit 1 = data, bit 2 = clock and bit 3 = collision. The default LOW_MASK is 4'b1001.
- R5: If pkt_en_i is high at a clock edge, shr_rx_o is all zero after that edge, whatever is on shr_pad_i.
- R6: If pkt_en_i is low at a clock edge, shr_rx_o after that edge equals shr_pad_i XOR (LOW_MASK AND NOT invert_i), using the values sampled at that edge.
- R7: Lines whose LOW_MASK bit is 0 (data and clock by default) pass through in both directions without change, for either value of invert_i.
- R8: ack_in_o follows ack_in_i and ack_out_o follows ack_out_i, with no clock delay.
- R9: pkt_en_o equals pkt_en_i, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| invert_i | input | 1 | 1 selects active-high bus polarity |
| ack_in_i | input | 1 | Arbitration acknowledge from the chain pad |
| ack_in_o | output | 1 | Arbitration acknowledge to the internal logic |
| ack_out_i | input | 1 | Acknowledge from the internal logic |
| ack_out_o | output | 1 | Acknowledge to the next device in the chain |
| wor_act_i | input | NUM_WOR | Internal wired-OR assert requests (active high) |
| wor_drv_o | output | NUM_WOR | Wired-OR drive pad value |
| wor_drv_oe_o | output | NUM_WOR | Wired-OR drive pad enable |
| wor_sense_i | input | NUM_WOR | Wired-OR sense pads |
| wor_sense_o | output | NUM_WOR | Registered sensed wired-OR state (active high) |
| pkt_en_i | input | 1 | Internal request to drive the shared lines |
| pkt_en_o | output | 1 | Transceiver drive enable / sense disable |
| shr_tx_i | input | NUM_SHR | Internal values for the shared lines (active high) |
| shr_pad_o | output | NUM_SHR | Shared pad output values |
| shr_oe_o | output | NUM_SHR | Shared pad output enables |
| shr_pad_i | input | NUM_SHR | Shared pad input values |
| shr_rx_o | output | NUM_SHR | Registered received shared values (active high) |

## Verification
The bench uses the defaults: two wired-OR lines and four shared lines with LOW_MASK 4'b1001. Under these settings the mask has both set and clear bits, so a single build covers lines that follow the polarity input and lines that do not. Random stimulus changes invert_i and pkt_en_i on every cycle, which exercises the moments where polarity changes together with pad values, and where sensing is blocked while the pads carry opposite traffic. Directed cases hold all pads at 1 and at 0 in both polarities.

// File: rtl/bb_bus_pkg.sv
package bb_bus_pkg;
  localparam int unsigned SHR_LINES = 4;
  localparam int unsigned SHR_EN    = 0;
  localparam int unsigned SHR_COL   = 3;
  localparam logic [SHR_LINES-1:0] DEF_LOW_MASK =
      (SHR_LINES'(1) << SHR_EN) | (SHR_LINES'(1) << SHR_COL);
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;
endpackage

// File: rtl/bb_wor_lane.sv
module bb_wor_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic act_i,
  input  logic sense_pad_i,
  output logic drv_o,
  output logic drv_oe_o,
  output logic sense_o
);
  logic sense_q;

  // open-drain: enable only when asserting, value pinned to asserted level
  assign drv_oe_o = act_i;
  assign drv_o    = hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sense_q <= 1'b0;
    else         sense_q <= (sense_pad_i == hi_i);
  end

  assign sense_o = sense_q;
endmodule

// File: rtl/bb_shr_lane.sv
module bb_shr_lane #(
  parameter bit LOW_DEF = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic drv_en_i,
  input  logic tx_i,
  input  logic pad_i,
  output logic pad_o,
  output logic oe_o,
  output logic rx_o
);
  logic flip;
  logic rx_q;

  assign flip  = LOW_DEF & ~hi_i;
  assign pad_o = tx_i ^ flip;
  assign oe_o  = drv_en_i;

  // sensing blocked while this device owns the line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= 1'b0;
    else if (drv_en_i) rx_q <= 1'b0;
    else               rx_q <= pad_i ^ flip;
  end

  assign rx_o = rx_q;
endmodule

// File: rtl/bb_bus_if.sv
module bb_bus_if #(
  parameter int unsigned NUM_WOR  = 2,
  parameter int unsigned NUM_SHR  = bb_bus_pkg::SHR_LINES,
  parameter logic [NUM_SHR-1:0] LOW_MASK = bb_bus_pkg::DEF_LOW_MASK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               invert_i,
  input  logic               ack_in_i,
  output logic               ack_in_o,
  input  logic               ack_out_i,
  output logic               ack_out_o,
  input  logic [NUM_WOR-1:0] wor_act_i,
  output logic [NUM_WOR-1:0] wor_drv_o,
  output logic [NUM_WOR-1:0] wor_drv_oe_o,
  input  logic [NUM_WOR-1:0] wor_sense_i,
  output logic [NUM_WOR-1:0] wor_sense_o,
  input  logic               pkt_en_i,
  output logic               pkt_en_o,
  input  logic [NUM_SHR-1:0] shr_tx_i,
  output logic [NUM_SHR-1:0] shr_pad_o,
  output logic [NUM_SHR-1:0] shr_oe_o,
  input  logic [NUM_SHR-1:0] shr_pad_i,
  output logic [NUM_SHR-1:0] shr_rx_o
);
  import bb_bus_pkg::*;

  pol_e pol;
  logic hi;

  assign pol       = pol_e'(invert_i);
  assign hi        = (pol == POL_HIGH);
  assign ack_in_o  = ack_in_i;
  assign ack_out_o = ack_out_i;
  assign pkt_en_o  = pkt_en_i;

  for (genvar k = 0; k < NUM_WOR; k++) begin : g_wor
    bb_wor_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hi_i        (hi),
      .act_i       (wor_act_i[k]),
      .sense_pad_i (wor_sense_i[k]),
      .drv_o       (wor_drv_o[k]),
      .drv_oe_o    (wor_drv_oe_o[k]),
      .sense_o     (wor_sense_o[k])
    );
  end

  for (genvar k = 0; k < NUM_SHR; k++) begin : g_shr
    bb_shr_lane #(.LOW_DEF(LOW_MASK[k])) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hi_i     (hi),
      .drv_en_i (pkt_en_i),
      .tx_i     (shr_tx_i[k]),
      .pad_i    (shr_pad_i[k]),
      .pad_o    (shr_pad_o[k]),
      .oe_o     (shr_oe_o[k]),
      .rx_o     (shr_rx_o[k])
    );
  end
endmodule

// File: rtl/bb_bus_if_chk.sv
module bb_bus_if_chk #(
  parameter int unsigned NUM_WOR  = 2,
  parameter int unsigned NUM_SHR  = 4,
  parameter logic [NUM_SHR-1:0] LOW_MASK = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               invert_i,
  input logic [NUM_WOR-1:0] wor_act_i,
  input logic [NUM_WOR-1:0] wor_drv_o,
  input logic [NUM_WOR-1:0] wor_drv_oe_o,
  input logic [NUM_WOR-1:0] wor_sense_i,
  input logic [NUM_WOR-1:0] wor_sense_o,
  input logic               pkt_en_i,
  input logic [NUM_SHR-1:0] shr_pad_i,
  input logic [NUM_SHR-1:0] shr_oe_o,
  input logic [NUM_SHR-1:0] shr_rx_o
);
  logic [NUM_SHR-1:0] flip;
  assign flip = LOW_MASK & ~{NUM_SHR{invert_i}};

  // R1
  always_comb if (!rst_ni) rst_quiet_chk: assert (wor_sense_o == '0 && shr_rx_o == '0);

  // R2
  od_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wor_drv_oe_o == wor_act_i) && (wor_drv_o == {NUM_WOR{invert_i}}));

  // R3
  wor_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> wor_sense_o == $past(~(wor_sense_i ^ {NUM_WOR{invert_i}})));

  // R4
  shr_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_oe_o == {NUM_SHR{pkt_en_i}});

  // R5
  sense_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_en_i |=> shr_rx_o == '0);

  // R6
  shr_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_en_i |=> shr_rx_o == $past(shr_pad_i ^ flip));
endmodule

bind bb_bus_if bb_bus_if_chk #(
  .NUM_WOR(NUM_WOR), .NUM_SHR(NUM_SHR), .LOW_MASK(LOW_MASK)
) u_chk (.*);

// File: tb/tb_bb_bus_if.sv
module tb_bb_bus_if;
  localparam int NW = 2;
  localparam int NS = 4;
  localparam logic [NS-1:0] MASK = 4'b1001;

  logic clk = 1'b0, rst_ni = 1'b0, invert_i = 1'b0;
  logic ack_in_i = 1'b0, ack_out_i = 1'b0, pkt_en_i = 1'b0;
  logic ack_in_o, ack_out_o, pkt_en_o;
  logic [NW-1:0] wor_act_i = '0, wor_sense_i = '0;
  logic [NW-1:0] wor_drv_o, wor_drv_oe_o, wor_sense_o;
  logic [NS-1:0] shr_tx_i = '0, shr_pad_i = '0;
  logic [NS-1:0] shr_pad_o, shr_oe_o, shr_rx_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bb_bus_if dut (.clk_i(clk), .*);

  function automatic logic [NS-1:0] flip_f(logic inv);
    return MASK & ~{NS{inv}};
  endfunction
  function automatic logic [NW-1:0] wor_rx_f(logic [NW-1:0] pad, logic inv);
    return ~(pad ^ {NW{inv}});
  endfunction
  function automatic logic [NS-1:0] shr_rx_f(logic [NS-1:0] pad, logic inv, logic en);
    return en ? '0 : (pad ^ flip_f(inv));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic comb_checks();
    chk(wor_drv_oe_o == wor_act_i, "R2 oe", 32'(wor_drv_oe_o), 32'(wor_act_i));
    chk(wor_drv_o == {NW{invert_i}}, "R2 level", 32'(wor_drv_o), 32'({NW{invert_i}}));
    chk(shr_oe_o == {NS{pkt_en_i}}, "R4 oe", 32'(shr_oe_o), 32'({NS{pkt_en_i}}));
    chk(shr_pad_o == (shr_tx_i ^ flip_f(invert_i)), "R4 pad",
        32'(shr_pad_o), 32'(shr_tx_i ^ flip_f(invert_i)));
    chk(shr_pad_o[2:1] == shr_tx_i[2:1], "R7 tx", 32'(shr_pad_o[2:1]), 32'(shr_tx_i[2:1]));
    chk(ack_in_o == ack_in_i && ack_out_o == ack_out_i, "R8",
        32'({ack_in_o, ack_out_o}), 32'({ack_in_i, ack_out_i}));
    chk(pkt_en_o == pkt_en_i, "R9", 32'(pkt_en_o), 32'(pkt_en_i));
  endtask

  // drive at negedge, check comb, then registered result after next posedge
  task automatic step(logic inv, logic en, logic [NW-1:0] act, logic [NW-1:0] wpad,
                      logic [NS-1:0] tx, logic [NS-1:0] spad, logic [1:0] ack);
    logic [NW-1:0] exp_w;
    logic [NS-1:0] exp_s;
    @(negedge clk);
    invert_i = inv; pkt_en_i = en; wor_act_i = act; wor_sense_i = wpad;
    shr_tx_i = tx; shr_pad_i = spad; {ack_in_i, ack_out_i} = ack;
    #1;
    comb_checks();
    exp_w = wor_rx_f(wpad, inv);
    exp_s = shr_rx_f(spad, inv, en);
    @(posedge clk); #1;
    chk(wor_sense_o == exp_w, "R3", 32'(wor_sense_o), 32'(exp_w));
    if (en) chk(shr_rx_o == '0, "R5", 32'(shr_rx_o), 32'h0);
    else begin
      chk(shr_rx_o == exp_s, "R6", 32'(shr_rx_o), 32'(exp_s));
      chk(shr_rx_o[2:1] == spad[2:1], "R7 rx", 32'(shr_rx_o[2:1]), 32'(spad[2:1]));
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    shr_pad_i = 4'b1111; wor_sense_i = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(wor_sense_o == '0 && shr_rx_o == '0, "R1",
        32'({wor_sense_o, shr_rx_o}), 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // directed corners in both polarities
    step(1'b0, 1'b0, 2'b11, 2'b00, 4'b1111, 4'b1111, 2'b10);
    step(1'b0, 1'b0, 2'b00, 2'b11, 4'b0000, 4'b0000, 2'b01);
    step(1'b1, 1'b0, 2'b01, 2'b11, 4'b1111, 4'b0000, 2'b11);
    step(1'b1, 1'b0, 2'b10, 2'b00, 4'b0110, 4'b1111, 2'b00);
    step(1'b0, 1'b1, 2'b11, 2'b01, 4'b1001, 4'b0110, 2'b10);
    step(1'b1, 1'b1, 2'b00, 2'b10, 4'b0101, 4'b1111, 2'b01);

    for (int i = 0; i < 400; i++)
      step(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
           4'($urandom), 4'($urandom), 2'($urandom));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule